// File: doc/BRIEF.md
# Receive Byte Buffer with Break Marking

This block sits between a serial deserializer and a host register interface. It holds up to four received bytes and hands them to the host oldest first. A byte is taken from the deserializer only while the receiver is enabled and the buffer has room, and the block says whether it took the byte through a same-cycle accept output.

A line-break event always leaves a mark in the stream: a zero byte is stored and a sticky break-change interrupt flag is raised, which the host clears with a separate strobe. When a break arrives with the buffer already full, the zero replaces the newest stored byte so the break is never lost. The host sees the oldest byte on the read-data output at all times. A pop strobe consumes it, and a pop on an empty buffer reads zero and does nothing. A flush input empties the buffer at once.

Top module: `rx_byte_fifo4`

## Requirements
- R1: The buffer holds at most 4 bytes and `pop_data` always presents the oldest held byte, so bytes leave in the order they were stored.
- R2: A data byte is taken (`push_accept` high in the same cycle as `push_valid`) only when `rx_en` is 1, `full` is 0, `flush` is 0 and no break is present; otherwise it is dropped and the buffer is unchanged.
- R3: Every `brk_pulse` stores a byte of value 0x00 and sets `brk_flag` on the following edge; `brk_clr` clears `brk_flag`, and a break in the same cycle as `brk_clr` leaves the flag set.
- R4: A `brk_pulse` while 4 bytes are held and no pop occurs overwrites the newest (fourth) byte with 0x00 and the count stays 4; with a pop in the same cycle the oldest byte leaves first and the zero is appended.
- R5: `rdy` is 1 whenever at least one byte is held, and `full` is 1 exactly when 4 bytes are held; a pop from a full buffer clears `full`.
- R6: A pop on an empty buffer returns 0x00 on `pop_data` and changes no state.
- R7: `flush` empties the buffer on the next edge, clearing `rdy` and `full`; a data byte offered in that cycle is not taken.
- R8: A pop and an accepted push in the same cycle on a non-empty buffer remove the oldest byte and store the new one, leaving the count unchanged.
- R9: A break has priority over a data byte offered in the same cycle; the data byte is not accepted.
- R10: After reset the buffer is empty: `rdy`, `full` and `brk_flag` are 0 and `pop_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; data bytes are taken only while high |
| flush | input | 1 | Empty the buffer |
| push_valid | input | 1 | Deserializer offers a byte |
| push_data | input | 8 | Offered byte |
| push_accept | output | 1 | Offered byte is taken this cycle |
| brk_pulse | input | 1 | One-cycle line-break event |
| brk_clr | input | 1 | Clear the break-change interrupt flag |
| pop | input | 1 | Host consumes the oldest byte |
| pop_data | output | 8 | Oldest held byte, 0x00 when empty |
| rdy | output | 1 | At least one byte held |
| full | output | 1 | Four bytes held |
| brk_flag | output | 1 | Sticky break-change interrupt flag |

## Verification
`push_accept` and `pop_data` are combinational and are due in the same cycle the inputs are applied, while `rdy`, `full`, `brk_flag` and the new head byte are due one edge later. The bench drives inputs on the falling edge, samples the combinational results 1 ns later before the rising edge, and samples the registered results 1 ns after that rising edge. A queue model, updated from the requirements at the moment each stimulus is applied, supplies every expected value, including the overwrite of the newest entry on a break at full.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl #(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             flush,
  input  logic             push_valid,
  input  logic             brk_pulse,
  input  logic             brk_clr,
  input  logic             pop,
  output logic             push_accept,
  output logic             wr_en,
  output logic             wr_zero,
  output logic [PTR_W-1:0] wr_idx,
  output logic [PTR_W-1:0] rd_idx,
  output logic             empty,
  output logic             full,
  output logic             brk_flag
);
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             brk_q, brk_d;
  logic             do_pop, do_brk, overwrite, grow;

  // status decode
  always_comb begin
    empty = (cnt_q == '0);
    full  = (cnt_q == CNT_W'(DEPTH));
  end

  // next-state
  always_comb begin
    do_pop      = pop & ~empty & ~flush;
    do_brk      = brk_pulse & ~flush;
    push_accept = push_valid & rx_en & ~full & ~brk_pulse & ~flush;
    overwrite   = do_brk & full & ~do_pop;
    wr_en       = do_brk | push_accept;
    wr_zero     = do_brk;
    grow        = wr_en & ~overwrite;
    if (overwrite) wr_idx = rd_ptr_q + PTR_W'(DEPTH - 1);
    else           wr_idx = rd_ptr_q + cnt_q[PTR_W-1:0];
    rd_idx = rd_ptr_q;

    if (flush) begin
      cnt_d    = '0;
      rd_ptr_d = '0;
    end else begin
      cnt_d    = cnt_q - CNT_W'(do_pop) + CNT_W'(grow);
      rd_ptr_d = rd_ptr_q + PTR_W'(do_pop);
    end

    if (brk_pulse)    brk_d = 1'b1;
    else if (brk_clr) brk_d = 1'b0;
    else              brk_d = brk_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      rd_ptr_q <= '0;
      brk_q    <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      rd_ptr_q <= rd_ptr_d;
      brk_q    <= brk_d;
    end
  end

  assign brk_flag = brk_q;
endmodule

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_idx,
  input  byte_t            wr_data,
  input  logic [PTR_W-1:0] rd_idx,
  output byte_t            rd_data
);
  byte_t mem_q [DEPTH];

  // one enable per entry
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic ent_we;
    assign ent_we = wr_en & (wr_idx == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (ent_we) mem_q[g] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/rx_byte_fifo4.sv
module rx_byte_fifo4
  import rxf_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       flush,
  input  logic       push_valid,
  input  logic [7:0] push_data,
  output logic       push_accept,
  input  logic       brk_pulse,
  input  logic       brk_clr,
  input  logic       pop,
  output logic [7:0] pop_data,
  output logic       rdy,
  output logic       full,
  output logic       brk_flag
);
  logic             wr_en, wr_zero, empty;
  logic [PTR_W-1:0] wr_idx, rd_idx;
  byte_t            wr_data, head;

  rxf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .flush      (flush),
    .push_valid (push_valid),
    .brk_pulse  (brk_pulse),
    .brk_clr    (brk_clr),
    .pop        (pop),
    .push_accept(push_accept),
    .wr_en      (wr_en),
    .wr_zero    (wr_zero),
    .wr_idx     (wr_idx),
    .rd_idx     (rd_idx),
    .empty      (empty),
    .full       (full),
    .brk_flag   (brk_flag)
  );

  assign wr_data = wr_zero ? byte_t'(0) : byte_t'(push_data);

  rxf_store #(.DEPTH(DEPTH)) u_store (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_data(wr_data),
    .rd_idx (rd_idx),
    .rd_data(head)
  );

  assign pop_data = empty ? 8'h00 : head;
  assign rdy      = ~empty;
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic       flush,
  input logic       push_valid,
  input logic       brk_pulse,
  input logic       pop,
  input logic       push_accept,
  input logic [7:0] pop_data,
  input logic       rdy,
  input logic       full,
  input logic       brk_flag
);
  a_r2_no_take_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push_accept);
  a_r2_no_take_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !push_accept);
  a_r3_break_raises_flag: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |=> brk_flag);
  a_r4_full_kept_on_break: assert property (@(posedge clk) disable iff (!rst_n)
    (full && brk_pulse && !pop && !flush) |=> full);
  a_r5_full_implies_ready: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> rdy);
  a_r6_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy |-> (pop_data == 8'h00));
  a_r6_empty_pop_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy && pop && !push_valid && !brk_pulse) |=> !rdy);
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!rdy && !full));
  a_r8_swap_keeps_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && pop && push_accept) |=> rdy);
  a_r9_break_blocks_data: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |-> !push_accept);
endmodule

bind rx_byte_fifo4 rxf_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_en      (rx_en),
  .flush      (flush),
  .push_valid (push_valid),
  .brk_pulse  (brk_pulse),
  .pop        (pop),
  .push_accept(push_accept),
  .pop_data   (pop_data),
  .rdy        (rdy),
  .full       (full),
  .brk_flag   (brk_flag)
);

// File: tb/tb_rx_byte_fifo4.sv
module tb_rx_byte_fifo4;
  logic       clk = 1'b0;
  logic       rst_n, rx_en, flush, push_valid, brk_pulse, brk_clr, pop;
  logic [7:0] push_data;
  logic       push_accept, rdy, full, brk_flag;
  logic [7:0] pop_data;

  int checks = 0;
  int errors = 0;

  logic [7:0] sb[$];
  logic       sb_brk = 1'b0;

  always #5 clk = ~clk;

  rx_byte_fifo4 dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .flush(flush),
    .push_valid(push_valid), .push_data(push_data), .push_accept(push_accept),
    .brk_pulse(brk_pulse), .brk_clr(brk_clr), .pop(pop), .pop_data(pop_data),
    .rdy(rdy), .full(full), .brk_flag(brk_flag)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus, updates the scoreboard, checks results
  task automatic step(input logic pv, input logic [7:0] pd, input logic brk,
                      input logic bc, input logic pp, input logic fl, input string tag);
    logic exp_acc;
    logic [7:0] exp_pd;
    @(negedge clk);
    push_valid = pv; push_data = pd; brk_pulse = brk; brk_clr = bc; pop = pp; flush = fl;
    #1;
    exp_acc = pv && rx_en && (sb.size() < 4) && !brk && !fl;
    exp_pd  = (sb.size() > 0) ? sb[0] : 8'h00;
    chk(tag, "push_accept", int'(push_accept), int'(exp_acc));
    chk(tag, "pop_data", int'(pop_data), int'(exp_pd));
    if (fl) sb.delete();
    else begin
      if (pp && sb.size() > 0) void'(sb.pop_front());
      if (brk) begin
        if (sb.size() == 4) sb[3] = 8'h00;
        else sb.push_back(8'h00);
      end else if (exp_acc) sb.push_back(pd);
    end
    if (brk) sb_brk = 1'b1;
    else if (bc) sb_brk = 1'b0;
    @(posedge clk);
    #1;
    push_valid = 0; brk_pulse = 0; brk_clr = 0; pop = 0; flush = 0;
    chk(tag, "rdy", int'(rdy), int'(sb.size() > 0));
    chk(tag, "full", int'(full), int'(sb.size() == 4));
    chk(tag, "brk_flag", int'(brk_flag), int'(sb_brk));
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; rx_en = 0; flush = 0; push_valid = 0; push_data = 0;
    brk_pulse = 0; brk_clr = 0; pop = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R10", "rdy", int'(rdy), 0);
    chk("R10", "full", int'(full), 0);
    chk("R10", "brk_flag", int'(brk_flag), 0);
    chk("R10", "pop_data", int'(pop_data), 0);

    // R2 receiver off
    step(1, 8'h55, 0, 0, 0, 0, "R2");
    rx_en = 1;
    // R1 ordering
    step(1, 8'hA1, 0, 0, 0, 0, "R1");
    step(1, 8'hA2, 0, 0, 0, 0, "R1");
    step(1, 8'hA3, 0, 0, 0, 0, "R1");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 0, "R1");
    // R5 fill to four
    for (int i = 0; i < 4; i++) step(1, 8'h10 + 8'(i), 0, 0, 0, 0, "R5");
    step(1, 8'hEE, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 1, 0, "R5");
    step(1, 8'h20, 0, 0, 0, 0, "R5");
    // R4 overwrite newest at full
    step(0, 0, 1, 0, 0, 0, "R4");
    step(0, 0, 0, 1, 0, 0, "R3");
    // R4 break with pop at full
    step(0, 0, 1, 0, 1, 0, "R4");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 0, "R1");
    // R6 empty pop
    step(0, 0, 0, 0, 1, 0, "R6");
    step(0, 0, 0, 0, 1, 0, "R6");
    // R3 break on partial buffer, then set wins over clear
    step(1, 8'h31, 0, 0, 0, 0, "R3");
    step(0, 0, 1, 0, 0, 0, "R3");
    step(0, 0, 0, 1, 0, 0, "R3");
    step(0, 0, 1, 1, 0, 0, "R3");
    // R8 push and pop together
    step(1, 8'h41, 0, 0, 1, 0, "R8");
    step(1, 8'h42, 0, 0, 1, 0, "R8");
    // R9 break beats data
    step(1, 8'h51, 1, 0, 0, 0, "R9");
    // R7 flush with a push
    step(1, 8'h61, 0, 0, 0, 1, "R7");
    step(0, 0, 0, 0, 1, 0, "R7");
    // mixed traffic
    for (int i = 0; i < 40; i++)
      step((i % 3) != 0, 8'(i * 7 + 3), (i % 11) == 5, (i % 13) == 2, (i % 2) == 1,
           (i % 17) == 16, "R1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule